// File: doc/BRIEF.md
# Multi-Channel PWM Bank with Buffered Duty Updates

The block drives a bank of pulse-width outputs from one shared period counter. The counter advances on an external enable tick and restarts after reaching a programmable terminal value, so every channel sees the same period of `period + 1` ticks. Each channel owns two edge registers: a rise position and a fall position. In normal mode the output is high while the counter sits at or after the rise position and before the fall position.

Channels can be built with a second, buffered copy of their edge registers. For those channels only, a run-time flag selects whether a bus write lands in the live edges at once or waits in the buffer until the next counter restart, where every buffered channel moves its buffer to the live edges in the same clock. Channels built without the buffer always take writes at once. A channel can be built as a pulse-density output instead of a compare output: each tick it adds a level to an accumulator modulo the period length, and the carry is the output. The result is a train of one-tick pulses with the requested average.

Software reaches all of this through a small APB-style register window with single-cycle access on the access phase and combinational read data.

Top module: `pwm_bank`

## Requirements
- R1: The shared counter advances by one on each clock where `tick` is 1. On a tick while it is at or above the period register it returns to 0 instead, so the period is `period + 1` ticks. Without a tick it holds.
- R2: A compare channel's output is registered: one clock after the counter value c is present, the output is 1 when rise <= c < fall and 0 otherwise. Equal edges give a constant 0; rise 0 with fall above the period gives a constant 1.
- R3: A write occurs on a clock where `psel`, `penable` and `pwrite` are all 1. Byte offsets: 0x00 is the period (low CNT_W bits), 0x04 is the buffered-update flag (bit 0), 0x10 + 8*n is channel n's rise position and 0x14 + 8*n its fall position. Reads return the last written value (for a buffered channel, the buffer). Any other offset reads 0, and writes to it change nothing.
- R4: On a channel built without the buffer, a write to either edge reaches the live edges at the next clock, whatever the flag says.
- R5: On a buffered channel with the flag at 0, a write reaches the live edges at the next clock.
- R6: On a buffered channel with the flag at 1, the live edges change only on a clock where the counter restarts. There, every buffered channel copies its buffer into its live edges.
- R7: With the flag at 1, a write whose access phase falls on the restart clock is stored in the buffer but reaches the live edges only at the following restart.
- R8: On a pulse-density channel, each tick adds the level (the fall register, capped at `period + 1`) to an accumulator modulo `period + 1`. The output for that tick is 1 when the addition wraps and is held between ticks. The rise register has no effect on the output.
- R9: A write to the period register clears every pulse-density accumulator and output at the same clock.
- R10: After reset the period, flag, all edges, buffers and accumulators are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter enable tick |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
The hardest case to reach is a write whose access phase lands on the exact clock where the counter restarts while buffered updates are on. It must go into the buffer but miss that restart. The bench follows the counter in its own model and starts the bus setup phase one tick before the terminal count, so the access phase lines up with the restart. It then watches that channel stay unchanged for a full period and change only after the second restart. Buffered-versus-immediate behaviour, the stalled tick and the accumulator clear on a period write are also checked at the outputs every clock against the model.

// File: rtl/pb_pkg.sv
package pb_pkg;
    localparam int unsigned OFS_PERIOD  = 'h00;
    localparam int unsigned OFS_FLAG    = 'h04;
    localparam int unsigned OFS_CH_BASE = 'h10;
    localparam int unsigned CH_STRIDE   = 8;
    localparam int unsigned CH_SHIFT    = $clog2(CH_STRIDE);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PERIOD,
        SEL_FLAG,
        SEL_CHAN
    } sel_e;
endpackage

// File: rtl/pb_timebase.sv
module pb_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        wrap    = tick && (state_q.cnt >= period);
        if (wrap) begin
            state_d.cnt = '0;
        end else if (tick) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt = state_q.cnt;

    assert_wrap_to_zero_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    assert_hold_without_tick_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/pb_regif.sv
module pb_regif
    import pb_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [31:0]                 pwdata,
    output logic [31:0]                 prdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0] rd_rise,
    input  logic [NUM_CH-1:0][CNT_W-1:0] rd_fall,
    output logic [CNT_W-1:0]            period,
    output logic                        buf_mode,
    output logic                        period_wr,
    output logic [NUM_CH-1:0]           wr_rise,
    output logic [NUM_CH-1:0]           wr_fall,
    output logic [CNT_W-1:0]            wdata
);
    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic             buf_mode;
    } regs_t;

    regs_t regs_d, regs_q;
    sel_e              sel;
    logic [ADDR_W-1:0] chan_idx;
    logic              hi_half;
    logic              wr_en;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^pwdata[31:CNT_W];

    always_comb begin
        wr_en    = psel && penable && pwrite;
        chan_idx = (paddr - ADDR_W'(OFS_CH_BASE)) >> CH_SHIFT;
        hi_half  = paddr[2];
        sel      = SEL_NONE;
        if (paddr[1:0] == 2'b00) begin
            if (paddr == ADDR_W'(OFS_PERIOD)) begin
                sel = SEL_PERIOD;
            end else if (paddr == ADDR_W'(OFS_FLAG)) begin
                sel = SEL_FLAG;
            end else if ((paddr >= ADDR_W'(OFS_CH_BASE)) && (chan_idx < ADDR_W'(NUM_CH))) begin
                sel = SEL_CHAN;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            wr_rise[i] = wr_en && (sel == SEL_CHAN) && (chan_idx == ADDR_W'(i)) && !hi_half;
            wr_fall[i] = wr_en && (sel == SEL_CHAN) && (chan_idx == ADDR_W'(i)) && hi_half;
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (sel == SEL_PERIOD)) begin
            regs_d.period = pwdata[CNT_W-1:0];
        end
        if (wr_en && (sel == SEL_FLAG)) begin
            regs_d.buf_mode = pwdata[0];
        end
    end

    always_comb begin
        prdata = '0;
        case (sel)
            SEL_PERIOD: prdata = 32'(regs_q.period);
            SEL_FLAG:   prdata = {31'b0, regs_q.buf_mode};
            SEL_CHAN: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (chan_idx == ADDR_W'(i)) begin
                        prdata = hi_half ? 32'(rd_fall[i]) : 32'(rd_rise[i]);
                    end
                end
            end
            default: prdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign period    = regs_q.period;
    assign buf_mode  = regs_q.buf_mode;
    assign period_wr = wr_en && (sel == SEL_PERIOD);
    assign wdata     = pwdata[CNT_W-1:0];

    assert_one_strobe_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_rise, wr_fall, period_wr}));

    assert_period_written_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> (period == $past(pwdata[CNT_W-1:0])));
endmodule

// File: rtl/pb_chan.sv
module pb_chan #(
    parameter int CNT_W      = 16,
    parameter bit HAS_BUFFER = 1'b1,
    parameter bit IS_DENSITY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic             buf_mode,
    input  logic             clear_acc,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic             wr_rise,
    input  logic             wr_fall,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rd_rise,
    output logic [CNT_W-1:0] rd_fall,
    output logic             pwm
);
    localparam int ACC_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] live_rise;
        logic [CNT_W-1:0] live_fall;
        logic [CNT_W-1:0] buf_rise;
        logic [CNT_W-1:0] buf_fall;
        logic [ACC_W-1:0] acc;
        logic             out;
    } chan_t;

    chan_t chan_d, chan_q;
    logic [ACC_W-1:0] acc_nx;
    logic             out_nx;

    generate
        if (IS_DENSITY) begin : g_density
            logic [ACC_W-1:0] modulus;
            logic [ACC_W-1:0] level;
            logic [ACC_W:0]   sum;
            logic             unused_cnt;

            assign unused_cnt = ^cnt;

            always_comb begin
                modulus = {1'b0, period} + ACC_W'(1);
                level   = (chan_q.live_fall > period) ? modulus : {1'b0, chan_q.live_fall};
                sum     = {1'b0, chan_q.acc} + {1'b0, level};
                acc_nx  = chan_q.acc;
                out_nx  = chan_q.out;
                if (clear_acc) begin
                    acc_nx = '0;
                    out_nx = 1'b0;
                end else if (tick) begin
                    if (sum >= {1'b0, modulus}) begin
                        acc_nx = ACC_W'(sum - {1'b0, modulus});
                        out_nx = 1'b1;
                    end else begin
                        acc_nx = sum[ACC_W-1:0];
                        out_nx = 1'b0;
                    end
                end
            end

            assert_acc_in_range_R8 : assert property (@(posedge clk) disable iff (!rst_n)
                chan_q.acc <= {1'b0, period});

            assert_clear_on_period_R9 : assert property (@(posedge clk) disable iff (!rst_n)
                clear_acc |=> ((chan_q.acc == '0) && !pwm));
        end else begin : g_compare
            logic unused_cmp_in;

            assign unused_cmp_in = ^{tick, period, clear_acc};

            always_comb begin
                acc_nx = '0;
                out_nx = (cnt >= chan_q.live_rise) && (cnt < chan_q.live_fall);
            end

            assert_equal_edges_low_R2 : assert property (@(posedge clk) disable iff (!rst_n)
                (chan_q.live_rise == chan_q.live_fall) |=> !pwm);
        end

        if (HAS_BUFFER) begin : g_buffered
            assert_async_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
                (wr_fall && !buf_mode) |=> (chan_q.live_fall == $past(wdata)));

            assert_hold_between_restarts_R6 : assert property (@(posedge clk) disable iff (!rst_n)
                (buf_mode && !wrap) |=> ($stable(chan_q.live_rise) && $stable(chan_q.live_fall)));

            assert_deferred_write_R7 : assert property (@(posedge clk) disable iff (!rst_n)
                (buf_mode && wrap && wr_rise) |=> (chan_q.live_rise == $past(chan_q.buf_rise)));
        end else begin : g_direct
            assert_direct_write_R4 : assert property (@(posedge clk) disable iff (!rst_n)
                wr_rise |=> (chan_q.live_rise == $past(wdata)));
        end
    endgenerate

    always_comb begin
        chan_d     = chan_q;
        chan_d.acc = acc_nx;
        chan_d.out = out_nx;
        if (HAS_BUFFER) begin
            if (buf_mode && wrap) begin
                chan_d.live_rise = chan_q.buf_rise;
                chan_d.live_fall = chan_q.buf_fall;
            end
            if (wr_rise) begin
                chan_d.buf_rise = wdata;
                if (!buf_mode) begin
                    chan_d.live_rise = wdata;
                end
            end
            if (wr_fall) begin
                chan_d.buf_fall = wdata;
                if (!buf_mode) begin
                    chan_d.live_fall = wdata;
                end
            end
        end else begin
            if (wr_rise) begin
                chan_d.live_rise = wdata;
            end
            if (wr_fall) begin
                chan_d.live_fall = wdata;
            end
            chan_d.buf_rise = '0;
            chan_d.buf_fall = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    assign rd_rise = HAS_BUFFER ? chan_q.buf_rise : chan_q.live_rise;
    assign rd_fall = HAS_BUFFER ? chan_q.buf_fall : chan_q.live_fall;
    assign pwm     = chan_q.out;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
    parameter int              NUM_CH      = 16,
    parameter int              CNT_W       = 16,
    parameter int              ADDR_W      = 8,
    parameter logic [NUM_CH-1:0] BUFFERED_CH = '1,
    parameter logic [NUM_CH-1:0] DENSITY_CH  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [CNT_W-1:0]             period;
    logic                         buf_mode;
    logic                         period_wr;
    logic [NUM_CH-1:0]            wr_rise;
    logic [NUM_CH-1:0]            wr_fall;
    logic [CNT_W-1:0]             wdata;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_rise;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_fall;
    logic [CNT_W-1:0]             cnt;
    logic                         wrap;

    pb_regif #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .rd_rise   (rd_rise),
        .rd_fall   (rd_fall),
        .period    (period),
        .buf_mode  (buf_mode),
        .period_wr (period_wr),
        .wr_rise   (wr_rise),
        .wr_fall   (wr_fall),
        .wdata     (wdata)
    );

    pb_timebase #(
        .CNT_W (CNT_W)
    ) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .period (period),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            pb_chan #(
                .CNT_W      (CNT_W),
                .HAS_BUFFER (BUFFERED_CH[i]),
                .IS_DENSITY (DENSITY_CH[i])
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .wrap      (wrap),
                .buf_mode  (buf_mode),
                .clear_acc (period_wr),
                .cnt       (cnt),
                .period    (period),
                .wr_rise   (wr_rise[i]),
                .wr_fall   (wr_fall[i]),
                .wdata     (wdata),
                .rd_rise   (rd_rise[i]),
                .rd_fall   (rd_fall[i]),
                .pwm       (pwm_out[i])
            );
        end
    endgenerate

    assert_reset_outputs_low_R10 : assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));
endmodule

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
    localparam int NC = 4;
    localparam int W  = 4;
    localparam logic [NC-1:0] BUF_M = 4'b0110;
    localparam logic [NC-1:0] DEN_M = 4'b1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NC-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pwm_bank #(
        .NUM_CH      (NC),
        .CNT_W       (W),
        .ADDR_W      (8),
        .BUFFERED_CH (BUF_M),
        .DENSITY_CH  (DEN_M)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pwm_out (pwm_out)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int m_per, m_flag, m_cnt;
    int m_lr[NC], m_lf[NC], m_br[NC], m_bf[NC], m_acc[NC];
    bit [NC-1:0] m_out;

    always @(posedge clk) begin
        int a, ch, val, md, lvl, s;
        bit wr, wrp, hi;
        if (!rst_n) begin
            m_per = 0; m_flag = 0; m_cnt = 0; m_out = '0;
            for (int i = 0; i < NC; i++) begin
                m_lr[i] = 0; m_lf[i] = 0; m_br[i] = 0; m_bf[i] = 0; m_acc[i] = 0;
            end
        end else begin
            wr = psel && penable && pwrite;
            a = int'(paddr);
            for (int i = 0; i < NC; i++) begin
                if (DEN_M[i]) begin
                    if (wr && a == 0) begin
                        m_acc[i] = 0; m_out[i] = 1'b0;
                    end else if (tick) begin
                        md = m_per + 1;
                        lvl = (m_lf[i] > m_per) ? md : m_lf[i];
                        s = m_acc[i] + lvl;
                        if (s >= md) begin m_acc[i] = s - md; m_out[i] = 1'b1; end
                        else begin m_acc[i] = s; m_out[i] = 1'b0; end
                    end
                end else begin
                    m_out[i] = (m_cnt >= m_lr[i]) && (m_cnt < m_lf[i]);
                end
            end
            wrp = tick && (m_cnt >= m_per);
            for (int i = 0; i < NC; i++) begin
                if (BUF_M[i] && m_flag != 0 && wrp) begin
                    m_lr[i] = m_br[i]; m_lf[i] = m_bf[i];
                end
            end
            ch = -1; hi = 1'b0;
            if (wr && a >= 16 && (a % 4) == 0 && (a - 16) / 8 < NC) begin
                ch = (a - 16) / 8;
                hi = ((a - 16) % 8) == 4;
            end
            if (ch >= 0) begin
                val = int'(pwdata) & 15;
                if (BUF_M[ch]) begin
                    if (hi) m_bf[ch] = val; else m_br[ch] = val;
                    if (m_flag == 0) begin
                        if (hi) m_lf[ch] = val; else m_lr[ch] = val;
                    end
                end else begin
                    if (hi) m_lf[ch] = val; else m_lr[ch] = val;
                end
            end
            m_cnt = wrp ? 0 : (tick ? (m_cnt + 1) % 16 : m_cnt);
            if (wr && a == 0) m_per = int'(pwdata) & 15;
            if (wr && a == 4) m_flag = int'(pwdata) & 1;
        end
    end

    function automatic int exp_read(int a);
        int ch;
        bit hi;
        if (a == 0) return m_per;
        if (a == 4) return m_flag;
        if (a >= 16 && (a % 4) == 0 && (a - 16) / 8 < NC) begin
            ch = (a - 16) / 8;
            hi = ((a - 16) % 8) == 4;
            if (hi) return BUF_M[ch] ? m_bf[ch] : m_lf[ch];
            return BUF_M[ch] ? m_br[ch] : m_lr[ch];
        end
        return 0;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    // every-clock comparison of all outputs against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NC; i++) begin
                n_chk++;
                if (pwm_out[i] !== m_out[i]) begin
                    n_fail++;
                    $display("FAIL R2/R4/R5/R6/R7/R8 ch%0d at %0t got %b exp %b",
                             i, $time, pwm_out[i], m_out[i]);
                end
            end
        end
    end

    // called at a negedge; returns at the negedge after the write edge
    task automatic bus_write(int a, int v);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
        paddr = 8'(a); pwdata = 32'(v);
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(int a, string tag);
        paddr = 8'(a);
        #5;
        chk(tag, prdata, 32'(exp_read(a)));
    endtask

    task automatic count_high(int ch, int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(pwm_out[ch]);
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int c;
        logic [NC-1:0] held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 outputs after reset", 32'(pwm_out), 32'h0);
        bus_read('h00, "R10 period after reset");
        bus_read('h2C, "R10 edge register after reset");
        tick = 1'b1;

        // R3 register window
        @(negedge clk);
        bus_write('h00, 9);
        bus_read('h00, "R3 period readback");
        chk("R3 period value", prdata, 32'd9);
        bus_write('h04, 0);
        bus_write('h08, 5);
        bus_read('h08, "R3 unmapped read");
        chk("R3 unmapped value", prdata, 32'd0);
        bus_write('h30, 7);
        bus_read('h30, "R3 out-of-range channel read");
        chk("R3 out-of-range value", prdata, 32'd0);
        bus_write('h10, 0);
        bus_write('h14, 1);
        bus_read('h14, "R3 fall readback");
        chk("R3 fall value", prdata, 32'd1);

        // R1 one pulse per 10-tick period
        repeat (3) @(negedge clk);
        count_high(0, 30, c);
        chk("R1 pulses in 30 ticks", 32'(c), 32'd3);

        // R1 counter holds without tick
        tick = 1'b0;
        repeat (2) @(negedge clk);
        held = pwm_out;
        repeat (20) begin
            @(negedge clk);
            chk("R1 hold without tick", 32'(pwm_out), 32'(held));
        end
        tick = 1'b1;

        // R2 full and empty duty
        bus_write('h14, 15);
        @(negedge clk);
        count_high(0, 10, c);
        chk("R2 full duty", 32'(c), 32'd10);
        bus_write('h10, 3);
        bus_write('h14, 3);
        @(negedge clk);
        count_high(0, 10, c);
        chk("R2 equal edges", 32'(c), 32'd0);

        // R5 buffered channel, flag off
        bus_write('h1C, 15);
        @(negedge clk);
        chk("R5 immediate high", 32'(pwm_out[1]), 32'd1);
        bus_write('h1C, 0);
        @(negedge clk);
        chk("R5 immediate low", 32'(pwm_out[1]), 32'd0);

        // R6 buffered channel, flag on
        bus_write('h04, 1);
        while (m_cnt != 2) @(negedge clk);
        bus_write('h1C, 15);
        repeat (5) begin
            chk("R6 held until restart", 32'(pwm_out[1]), 32'd0);
            @(negedge clk);
        end
        bus_read('h1C, "R3 buffer readback");
        repeat (15) @(negedge clk);
        chk("R6 applied after restart", 32'(pwm_out[1]), 32'd1);

        // R4 unbuffered channel ignores the flag
        bus_write('h10, 0);
        bus_write('h14, 15);
        @(negedge clk);
        chk("R4 immediate with flag on", 32'(pwm_out[0]), 32'd1);

        // R7 write on the restart clock is deferred a full period
        while (m_cnt != 8) @(negedge clk);
        bus_write('h24, 15);
        repeat (9) begin
            chk("R7 deferred past restart", 32'(pwm_out[2]), 32'd0);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk("R7 applied at next restart", 32'(pwm_out[2]), 32'd1);

        // R8 pulse density
        bus_write('h28, 7);
        bus_write('h2C, 5);
        @(negedge clk);
        count_high(3, 20, c);
        chk("R8 half density", 32'(c), 32'd10);
        bus_write('h2C, 15);
        @(negedge clk);
        count_high(3, 20, c);
        chk("R8 capped level", 32'(c), 32'd20);
        bus_write('h2C, 0);
        @(negedge clk);
        count_high(3, 20, c);
        chk("R8 zero level, rise ignored", 32'(c), 32'd0);

        // R9 period write clears accumulator
        bus_write('h2C, 5);
        repeat (7) @(negedge clk);
        bus_write('h00, 9);
        chk("R9 cleared output", 32'(pwm_out[3]), 32'd0);
        @(negedge clk);
        chk("R9 first tick after clear", 32'(pwm_out[3]), 32'd0);
        @(negedge clk);
        chk("R9 second tick after clear", 32'(pwm_out[3]), 32'd1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule